// File: doc/BRIEF.md
# Reset-Qualified Boot Source Selector

This block decides, after each reset, whether a microcontroller core fetches its program from an internal boot ROM or from external program memory. It measures how long the active-low reset pin stays low by counting cycles of a free-running clock of known frequency. When the pin is released, it samples a strap level that an external comparator has already digitized. It then latches the chosen source in a sticky flag and holds the core in reset until that choice is final.

Boot ROM is chosen only after a long reset that ends with the strap high, provided the strap then stays high for a short hold window. A short reset always selects external memory. A reset of intermediate length keeps the previous choice, unless the strap is low at release. Both input pins pass through two-flop synchronizers. All durations are measured in cycles of the synchronized reset, which are equal to the number of clock cycles the pin was low. The thresholds are computed from `CLK_HZ`: LONG_CYC = CLK_HZ·LONG_MS/1000, SHORT_CYC = CLK_HZ·SHORT_MS/1000, and HOLD_CYC = ceil(CLK_HZ·HOLD_NS/1e9), with a minimum of 1.

Top module: `bootsel_top`

## Requirements
- R1: A reset held low for at least LONG_CYC cycles, released with the strap high, and followed by HOLD_CYC further cycles of high synchronized strap sets `boot_mode` to 1 (1 = boot ROM, 0 = external memory).
- R2: If the strap goes low at any point during the hold window after a long reset, the result is `boot_mode` = 0.
- R3: A reset held low for fewer than SHORT_CYC cycles gives `boot_mode` = 0, whatever the strap level.
- R4: A reset of any length that is released with the strap low gives `boot_mode` = 0.
- R5: A reset held low for at least SHORT_CYC and fewer than LONG_CYC cycles, released with the strap high, leaves `boot_mode` at its previous value. The mode flag is never cleared by the reset pin itself.
- R6: While `por_n` is low, `boot_mode` is 0 and `core_rst_n` is 0.
- R7: `core_rst_n` is 0 while the synchronized reset is low and throughout the strap hold check. It becomes 1 only once the mode has been decided.
- R8: Changes on the strap while the core is running do not alter `boot_mode` or `fetch_boot`.
- R9: The duration counter saturates at LONG_CYC. A reset far longer than the long threshold behaves as a long reset.
- R10: `fetch_boot` always equals `boot_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of frequency CLK_HZ |
| por_n | input | 1 | Synchronous active-low power-on reset; the only input that clears the mode flag |
| ext_rst_n | input | 1 | Asynchronous active-low reset pin whose low time is measured |
| strap_in | input | 1 | Digitized strap level (1 = above half supply) |
| core_rst_n | output | 1 | Active-low reset to the core |
| fetch_boot | output | 1 | Fetch-source select: 1 = boot ROM, 0 = external memory |
| boot_mode | output | 1 | Status copy of the latched mode |

## Verification
The hardest situation to reach is a long reset whose strap drops inside the hold window, after release has already been seen. The bench drives the pins on the falling clock edge, so the synchronizer latency is the same for both pins. It then lowers the strap exactly one cycle after raising the reset pin, and at that point the hold check has started but not finished. Threshold edges are reached by holding reset low for exactly LONG_CYC−1, LONG_CYC, SHORT_CYC−1 and SHORT_CYC cycles, with the thresholds scaled down through `CLK_HZ`. The sticky behaviour is observed by running these pulses in an order where the expected result depends on the previous one.

// File: rtl/bootsel_pkg.sv
// Shared types for the boot source selector.
// Assumes: nothing beyond IEEE 1800-2017.
package bootsel_pkg;
    // Length class of a completed reset pulse
    typedef enum logic [1:0] {
        PW_SHORT = 2'd0,
        PW_MID   = 2'd1,
        PW_LONG  = 2'd2
    } pw_class_t;

    // Decision controller states
    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } sel_state_t;
endpackage

// File: rtl/bootsel_sync.sv
// Multi-bit, multi-stage synchronizer for independent level inputs.
// Assumes: each bit is a slow level, so skew between bits does not matter;
// STAGES >= 2. Clears to RST_VAL under synchronous active-low por_n.
module bootsel_sync #(
    parameter int unsigned       WIDTH   = 2,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the inputs through the synchronizing stages
    always_ff @(posedge clk) begin
        if (!por_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bootsel_pw_timer.sv
// Measures how long the synchronized reset stays low and classifies the
// pulse in the cycle its release is seen.
// Assumes: rst_s is synchronous; SHORT_CYC <= LONG_CYC. The counter stops
// at LONG_CYC and so never wraps.
module bootsel_pw_timer
    import bootsel_pkg::*;
#(
    parameter int unsigned LONG_CYC  = 1000,
    parameter int unsigned SHORT_CYC = 200,
    parameter int unsigned CNT_W     = $clog2(LONG_CYC + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_s,
    output logic             rel,
    output pw_class_t        cls,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC);

    logic rst_q;

    // Count low cycles (saturating) and remember the previous reset level
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt   <= '0;
            rst_q <= 1'b0;
        end else begin
            rst_q <= rst_s;
            if (rst_s) begin
                cnt <= '0;
            end else if (cnt < LONG_LIM) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Release is the first high cycle of the synchronized reset
    assign rel = rst_s & ~rst_q;

    // Classify the finished pulse from the count held up to release
    always_comb begin
        if (cnt >= LONG_LIM) begin
            cls = PW_LONG;
        end else if (cnt < SHORT_LIM) begin
            cls = PW_SHORT;
        end else begin
            cls = PW_MID;
        end
    end
endmodule

// File: rtl/bootsel_mode_ctl.sv
// Decides the boot source at each release, runs the strap hold check,
// keeps the sticky mode flag and drives the core reset.
// Assumes: rel and cls come from bootsel_pw_timer on the same synchronized
// reset; the mode flag is cleared only by por_n.
module bootsel_mode_ctl
    import bootsel_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned HOLD_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_s,
    input  logic       strap_s,
    input  logic       rel,
    input  pw_class_t  cls,
    output logic       mode,
    output logic       core_rst_n,
    output logic       in_hold
);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    sel_state_t        st;
    logic [HOLD_W-1:0] hcnt;

    // Sequence the decision and update mode and the core reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st         <= ST_HELD;
            mode       <= 1'b0;
            core_rst_n <= 1'b0;
            hcnt       <= '0;
        end else if (!rst_s) begin
            st         <= ST_HELD;
            core_rst_n <= 1'b0;
            hcnt       <= '0;
        end else begin
            unique case (st)
                ST_HELD: begin
                    if (rel) begin
                        if (!strap_s || cls == PW_SHORT) begin
                            mode       <= 1'b0;
                            st         <= ST_RUN;
                            core_rst_n <= 1'b1;
                        end else if (cls == PW_LONG) begin
                            st   <= ST_HOLD;
                            hcnt <= '0;
                        end else begin
                            st         <= ST_RUN;
                            core_rst_n <= 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!strap_s) begin
                        mode       <= 1'b0;
                        st         <= ST_RUN;
                        core_rst_n <= 1'b1;
                    end else if (hcnt == HOLD_LAST) begin
                        mode       <= 1'b1;
                        st         <= ST_RUN;
                        core_rst_n <= 1'b1;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: begin
                    st <= ST_RUN;
                end
            endcase
        end
    end

    assign in_hold = (st == ST_HOLD);
endmodule

// File: rtl/bootsel_top.sv
// Boot source selector top: synchronizes the pins, times the reset pulse
// and latches the fetch source for the core.
// Assumes: clk runs freely at CLK_HZ; por_n is low for at least one cycle
// at power-up; strap_in is already a clean digital level.
module bootsel_top
    import bootsel_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 11_059_200,
    parameter int unsigned LONG_MS  = 2000,
    parameter int unsigned SHORT_MS = 400,
    parameter int unsigned HOLD_NS  = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic strap_in,
    output logic core_rst_n,
    output logic fetch_boot,
    output logic boot_mode
);
    localparam longint unsigned HZ64      = 64'(CLK_HZ);
    localparam longint unsigned LONG_L    = HZ64 * LONG_MS / 1000;
    localparam longint unsigned SHORT_L   = HZ64 * SHORT_MS / 1000;
    localparam longint unsigned HOLD_RAW  = (HZ64 * HOLD_NS + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int unsigned     LONG_CYC  = 32'(LONG_L);
    localparam int unsigned     SHORT_CYC = 32'(SHORT_L);
    localparam int unsigned     HOLD_CYC  = (HOLD_RAW == 0) ? 1 : 32'(HOLD_RAW);
    localparam int unsigned     CNT_W     = $clog2(LONG_CYC + 1);
    localparam int unsigned     HOLD_W    = $clog2(HOLD_CYC + 1);

    logic [1:0]       sync_q;
    logic             rst_s;
    logic             strap_s;
    logic             rel;
    pw_class_t        cls;
    logic [CNT_W-1:0] cnt;
    logic             mode;
    logic             in_hold;

    bootsel_sync #(
        .WIDTH  (2),
        .STAGES (2),
        .RST_VAL(2'b00)
    ) u_sync (
        .clk  (clk),
        .por_n(por_n),
        .d    ({strap_in, ext_rst_n}),
        .q    (sync_q)
    );

    assign rst_s   = sync_q[0];
    assign strap_s = sync_q[1];

    bootsel_pw_timer #(
        .LONG_CYC (LONG_CYC),
        .SHORT_CYC(SHORT_CYC),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk  (clk),
        .por_n(por_n),
        .rst_s(rst_s),
        .rel  (rel),
        .cls  (cls),
        .cnt  (cnt)
    );

    bootsel_mode_ctl #(
        .HOLD_CYC(HOLD_CYC),
        .HOLD_W  (HOLD_W)
    ) u_ctl (
        .clk       (clk),
        .por_n     (por_n),
        .rst_s     (rst_s),
        .strap_s   (strap_s),
        .rel       (rel),
        .cls       (cls),
        .mode      (mode),
        .core_rst_n(core_rst_n),
        .in_hold   (in_hold)
    );

    assign fetch_boot = mode;
    assign boot_mode  = mode;
endmodule

// File: rtl/bootsel_chk.sv
// Property checker for bootsel_top, attached with bind below.
// Assumes: connected to the top's synchronized signals and outputs.
module bootsel_chk
    import bootsel_pkg::*;
#(
    parameter int unsigned LONG_CYC = 1000,
    parameter int unsigned CNT_W    = 10
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_s,
    input logic             strap_s,
    input logic             rel,
    input pw_class_t        cls,
    input logic [CNT_W-1:0] cnt,
    input logic             in_hold,
    input logic             core_rst_n,
    input logic             fetch_boot,
    input logic             boot_mode
);
    p_rise_needs_strap_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(boot_mode) |-> $past(strap_s) && $past(in_hold));

    p_short_normal_r3: assert property (@(posedge clk) disable iff (!por_n)
        (rel && cls == PW_SHORT) |=> !boot_mode);

    p_strap_low_normal_r4: assert property (@(posedge clk) disable iff (!por_n)
        (rel && !strap_s) |=> !boot_mode);

    p_core_held_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_s || in_hold) |=> !core_rst_n || rst_s);

    p_stable_run_r8: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst_n && $past(core_rst_n)) |-> $stable(boot_mode));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= CNT_W'(LONG_CYC));

    p_fetch_match_r10: assert property (@(posedge clk) disable iff (!por_n)
        fetch_boot == boot_mode);
endmodule

bind bootsel_top bootsel_chk #(
    .LONG_CYC(LONG_CYC),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_s     (rst_s),
    .strap_s   (strap_s),
    .rel       (rel),
    .cls       (cls),
    .cnt       (cnt),
    .in_hold   (in_hold),
    .core_rst_n(core_rst_n),
    .fetch_boot(fetch_boot),
    .boot_mode (boot_mode)
);

// File: tb/tb_bootsel_top.sv
// Bench for bootsel_top: a vector table of reset pulses, then directed tests.
// CLK_HZ=5000 scales the thresholds to LONG=10000, SHORT=2000, HOLD=5 cycles.
module tb_bootsel_top;
    localparam int unsigned LONG  = 10000;
    localparam int unsigned SHORT = 2000;
    localparam int unsigned HOLD  = 5;

    logic clk = 1'b0;
    logic por_n;
    logic ext_rst_n;
    logic strap_in;
    logic core_rst_n;
    logic fetch_boot;
    logic boot_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bootsel_top #(
        .CLK_HZ  (5000),
        .LONG_MS (2000),
        .SHORT_MS(400),
        .HOLD_NS (1_000_000)
    ) dut (
        .clk       (clk),
        .por_n     (por_n),
        .ext_rst_n (ext_rst_n),
        .strap_in  (strap_in),
        .core_rst_n(core_rst_n),
        .fetch_boot(fetch_boot),
        .boot_mode (boot_mode)
    );

    // Columns: low cycles, strap level, strap drop delay (0 = keep), expected mode, requirement
    localparam int unsigned NV = 12;
    localparam int unsigned TBL [NV][5] = '{
        '{500,        1, 0, 0, 3},   // R3 short pulse
        '{LONG,       1, 0, 1, 1},   // R1 long, strap held
        '{5000,       1, 0, 1, 5},   // R5 mid keeps boot
        '{5000,       0, 0, 0, 4},   // R4 strap low at release
        '{LONG,       1, 1, 0, 2},   // R2 strap drops in hold window
        '{LONG,       1, 0, 1, 1},   // R1
        '{SHORT - 1,  1, 0, 0, 3},   // R3 just below short threshold
        '{LONG,       1, 0, 1, 1},   // R1 exactly at long threshold
        '{SHORT,      1, 0, 1, 5},   // R5 exactly at short threshold keeps
        '{LONG,       0, 0, 0, 4},   // R4 long but strap low
        '{LONG - 1,   1, 0, 0, 5},   // R5 one below long keeps normal
        '{LONG + 5000,1, 0, 1, 9}    // R9 far beyond long threshold
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int unsigned low, input logic strap, input int unsigned drop);
        @(negedge clk);
        strap_in  = strap;
        ext_rst_n = 1'b0;
        repeat (low) @(negedge clk);
        ext_rst_n = 1'b1;
        if (drop > 0) begin
            repeat (drop) @(negedge clk);
            strap_in = 1'b0;
        end
        repeat (20) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        por_n     = 1'b0;
        ext_rst_n = 1'b1;
        strap_in  = 1'b0;
        repeat (5) @(negedge clk);
        check("R6", boot_mode, 1'b0, "mode during por");
        check("R6", core_rst_n, 1'b0, "core reset during por");
        por_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R6", boot_mode, 1'b0, "mode after por");
        check("R7", core_rst_n, 1'b1, "core released after por");

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d row%0d", TBL[i][4], i);
            pulse(TBL[i][0], TBL[i][1][0], TBL[i][2]);
            check(rq, boot_mode, TBL[i][3][0], "boot_mode");
            check("R10", fetch_boot, TBL[i][3][0], "fetch_boot");
            check("R7", core_rst_n, 1'b1, "core running");
        end

        // R8: strap toggles while running do not move the mode (currently 1)
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            strap_in = ~strap_in;
            repeat (6) @(negedge clk);
            check("R8", boot_mode, 1'b1, "mode after strap toggle");
            check("R8", fetch_boot, 1'b1, "fetch after strap toggle");
        end

        // R7: core reset held during the pin low time and the hold check
        @(negedge clk);
        strap_in  = 1'b1;
        ext_rst_n = 1'b0;
        repeat (100) @(negedge clk);
        check("R7", core_rst_n, 1'b0, "core held while pin low");
        check("R5", boot_mode, 1'b1, "mode kept while pin low");
        repeat (LONG - 100) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7", core_rst_n, 1'b0, "core held in hold check");
        repeat (HOLD + 6) @(negedge clk);
        check("R7", core_rst_n, 1'b1, "core released after hold");
        check("R1", boot_mode, 1'b1, "boot after hold");

        // R3: short pulse with strap high drops boot mode
        pulse(10, 1'b1, 0);
        check("R3", boot_mode, 1'b0, "short pulse, strap high");
        check("R10", fetch_boot, 1'b0, "fetch after short pulse");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule